// File: doc/BRIEF.md
# Three-Band Cascaded Biquad Equalizer Core

This core applies three second-order recursive filter sections, one after another, to a stereo stream of signed 16-bit audio samples. The sections stand for the low, mid and high bands. Each section owns one multiplier and one accumulator. A small state machine steps that single unit through the five products of the left channel and then the five of the right. The filter form is y = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2, with signed coefficients in Q2.14 format.

A sample pair enters with a one-cycle strobe. Every section begins work on the same strobe. Each section reads the value its upstream neighbour held from the previous period, and the first section reads an input register. As a result, a sample leaves the core three strobes after it arrived. Each section's accumulated sum is rounded, shifted back to sample scale and clipped to 16 bits before it becomes that section's output and recursive history.

A coefficient set where every b0 is 0x4000 and every other coefficient is zero passes audio through unchanged. The five coefficients of a section are captured only when that section starts a new sample, so software may rewrite them at any time.

Top module: `eq3_biquad_core`

## Requirements
- R1: While the synchronous reset `rst` is high, and afterwards until the first result, `out_l` and `out_r` read 0 and `out_valid` reads 0.
- R2: With b0 = 0x4000 and b1, b2, a1, a2 = 0 in all three sections, each output equals the input sample given three strobes earlier, including the values 32767 and −32768.
- R3: Each section computes y = b0·x + b1·x[n−1] + b2·x[n−2] − a1·y[n−1] − a2·y[n−2] per channel, with signed Q2.14 coefficients. The low section feeds the mid section, and the mid section feeds the high section.
- R4: The full-precision sum is rounded by adding 2^13 and arithmetically shifting right by 14. A result of exactly one half therefore rounds toward plus infinity: 0.5 gives 1, −0.5 gives 0, and −1.5 gives −1.
- R5: A rounded result above 32767 is stored and output as 32767. A result below −32768 is stored and output as −32768.
- R6: The output for the pair presented at strobe n appears with the `out_valid` pulse that follows strobe n+3. `out_valid` is high for exactly one cycle: the twelfth cycle after the cycle in which the strobe is sampled. The outputs change only when that pulse occurs.
- R7: A coefficient change made while a section is computing has no effect on the sample in progress. The change takes effect from the next strobe.
- R8: Left and right keep separate histories: an impulse on the left channel with zero on the right leaves the right output at zero.
- R9: A synchronous reset clears every stored input, output and history value. With zero input after reset, the outputs stay zero even when the recursive coefficients would otherwise ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new input pair |
| smp_l | input | DW (16) | Left input sample, signed |
| smp_r | input | DW (16) | Right input sample, signed |
| lo_b0 | input | CW (16) | Low section b0, Q2.14 |
| lo_b1 | input | CW (16) | Low section b1, Q2.14 |
| lo_b2 | input | CW (16) | Low section b2, Q2.14 |
| lo_a1 | input | CW (16) | Low section a1, Q2.14 |
| lo_a2 | input | CW (16) | Low section a2, Q2.14 |
| mid_b0 | input | CW (16) | Mid section b0, Q2.14 |
| mid_b1 | input | CW (16) | Mid section b1, Q2.14 |
| mid_b2 | input | CW (16) | Mid section b2, Q2.14 |
| mid_a1 | input | CW (16) | Mid section a1, Q2.14 |
| mid_a2 | input | CW (16) | Mid section a2, Q2.14 |
| hi_b0 | input | CW (16) | High section b0, Q2.14 |
| hi_b1 | input | CW (16) | High section b1, Q2.14 |
| hi_b2 | input | CW (16) | High section b2, Q2.14 |
| hi_a1 | input | CW (16) | High section a1, Q2.14 |
| hi_a2 | input | CW (16) | High section a2, Q2.14 |
| out_l | output | DW (16) | Filtered left sample, signed |
| out_r | output | DW (16) | Filtered right sample, signed |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |

## Verification
The bench targets several corner cases. Half-way rounding with negative values exposes a design that truncates, or that rounds symmetrically away from zero; such a design yields −1 instead of 0 for −0.5. Full-scale gains expose a missing or wrongly signed clip, which would make the output wrap around to the opposite polarity. Coefficients rewritten in the middle of a computation catch a design that reads the live ports, since it would mix old and new products in one sum. A left-only impulse and a reset during a ringing response catch shared channel history and history that survives reset: either fault leaves non-zero values where zeros are due. Long random runs with distinct per-section coefficients check the sign of the feedback terms and the cascade order.

// File: rtl/eq3_biquad_core.sv
module eq3_biquad_core #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int ACCW = 36
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_l,
  input  logic signed [DW-1:0] smp_r,
  input  logic signed [CW-1:0] lo_b0,
  input  logic signed [CW-1:0] lo_b1,
  input  logic signed [CW-1:0] lo_b2,
  input  logic signed [CW-1:0] lo_a1,
  input  logic signed [CW-1:0] lo_a2,
  input  logic signed [CW-1:0] mid_b0,
  input  logic signed [CW-1:0] mid_b1,
  input  logic signed [CW-1:0] mid_b2,
  input  logic signed [CW-1:0] mid_a1,
  input  logic signed [CW-1:0] mid_a2,
  input  logic signed [CW-1:0] hi_b0,
  input  logic signed [CW-1:0] hi_b1,
  input  logic signed [CW-1:0] hi_b2,
  input  logic signed [CW-1:0] hi_a1,
  input  logic signed [CW-1:0] hi_a2,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic                 out_valid
);
  localparam int NST  = 3;
  localparam int NTAP = 5;
  localparam int PW   = DW + CW;
  localparam logic [3:0] S_IDLE = 4'd0;
  localparam logic [3:0] S_L4   = 4'd5;
  localparam logic [3:0] S_R0   = 4'd6;
  localparam logic [3:0] S_R4   = 4'd10;
  localparam logic [3:0] S_UPD  = 4'd11;
  localparam logic signed [ACCW-1:0] RND    = ACCW'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW-1:0] SAT_HI = ACCW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] SAT_LO = ACCW'(-(1 <<< (DW - 1)));

  // R4, R5: round half up, then clip to the sample range
  function automatic logic signed [DW-1:0] sat_round(input logic signed [ACCW-1:0] a);
    logic signed [ACCW-1:0] t;
    t = (a + RND) >>> FRAC;
    if (t > SAT_HI)      return DW'(SAT_HI);
    else if (t < SAT_LO) return DW'(SAT_LO);
    else                 return DW'(t);
  endfunction

  logic signed [CW-1:0] cin [NST][NTAP];
  logic signed [DW-1:0] xin [NST][2];
  logic signed [DW-1:0] yo  [NST][2];
  logic signed [DW-1:0] in_l_q, in_r_q;
  logic [NST-1:0] idle, vld;

  assign cin[0][0] = lo_b0;  assign cin[0][1] = lo_b1;  assign cin[0][2] = lo_b2;
  assign cin[0][3] = lo_a1;  assign cin[0][4] = lo_a2;
  assign cin[1][0] = mid_b0; assign cin[1][1] = mid_b1; assign cin[1][2] = mid_b2;
  assign cin[1][3] = mid_a1; assign cin[1][4] = mid_a2;
  assign cin[2][0] = hi_b0;  assign cin[2][1] = hi_b1;  assign cin[2][2] = hi_b2;
  assign cin[2][3] = hi_a1;  assign cin[2][4] = hi_a2;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_l_q <= '0;
      in_r_q <= '0;
    end else if (smp_valid && (&idle)) begin
      in_l_q <= smp_l;
      in_r_q <= smp_r;
    end
  end

  assign xin[0][0] = in_l_q;
  assign xin[0][1] = in_r_q;

  genvar s;
  for (s = 0; s < NST; s++) begin : g_stg
    logic [3:0] st;
    logic signed [CW-1:0] cq [NTAP];
    logic signed [DW-1:0] xq [2], x1 [2], x2 [2], y1 [2], y2 [2];
    logic signed [DW-1:0] yl, yol, yor, opd, ynow;
    logic signed [ACCW-1:0] acc, acc_nx;
    logic signed [PW-1:0] prod;
    logic [2:0] tap;
    logic ch, vq;

    if (s > 0) begin : g_link
      assign xin[s][0] = yo[s-1][0];
      assign xin[s][1] = yo[s-1][1];
    end

    always_comb begin
      ch  = (st >= S_R0) && (st <= S_R4);
      tap = '0;
      if (st >= 4'd1 && st <= S_L4) tap = 3'(st - 4'd1);
      else if (ch)                  tap = 3'(st - S_R0);
      case (tap)
        3'd0:    opd = xq[ch];
        3'd1:    opd = x1[ch];
        3'd2:    opd = x2[ch];
        3'd3:    opd = y1[ch];
        default: opd = y2[ch];
      endcase
      prod   = cq[tap] * opd;
      acc_nx = ((tap == 3'd0) ? '0 : acc) + ((tap >= 3'd3) ? -ACCW'(prod) : ACCW'(prod));
      ynow   = sat_round(acc);
    end

    assign idle[s]  = (st == S_IDLE);
    assign vld[s]   = vq;
    assign yo[s][0] = yol;
    assign yo[s][1] = yor;

    always_ff @(posedge clk) begin
      if (rst) begin
        st  <= S_IDLE;
        acc <= '0;
        vq  <= 1'b0;
        yl  <= '0;
        yol <= '0;
        yor <= '0;
        for (int k = 0; k < NTAP; k++) cq[k] <= '0;
        for (int c = 0; c < 2; c++) begin
          xq[c] <= '0; x1[c] <= '0; x2[c] <= '0; y1[c] <= '0; y2[c] <= '0;
        end
      end else begin
        vq <= 1'b0;
        case (st)
          S_IDLE: if (smp_valid) begin
            st <= 4'd1;
            for (int k = 0; k < NTAP; k++) cq[k] <= cin[s][k];
            for (int c = 0; c < 2; c++) xq[c] <= xin[s][c];
          end
          S_UPD: begin
            for (int c = 0; c < 2; c++) begin
              x1[c] <= xq[c];
              x2[c] <= x1[c];
              y2[c] <= y1[c];
            end
            y1[0] <= yl;
            y1[1] <= ynow;
            yol   <= yl;
            yor   <= ynow;
            vq    <= 1'b1;
            st    <= S_IDLE;
          end
          default: begin
            acc <= acc_nx;
            if (st == S_R0) yl <= ynow;
            st <= st + 4'd1;
          end
        endcase
      end
    end
  end

  assign out_l     = yo[NST-1][0];
  assign out_r     = yo[NST-1][1];
  assign out_valid = &vld;
endmodule

// File: rtl/eq3_biquad_chk.sv
module eq3_biquad_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r
);
  logic [4:0] since;

  always_ff @(posedge clk) begin
    if (rst)                       since <= '0;
    else if (smp_valid)            since <= 5'd1;
    else if (since != '0 && since < 5'd20) since <= since + 5'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_l == '0 && out_r == '0));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_pulse_timing_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> since == 5'd12);

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(out_l) && $stable(out_r)));
endmodule

bind eq3_biquad_core eq3_biquad_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .smp_valid(smp_valid),
  .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
);

// File: tb/eq3_biquad_core_tb_top.sv
module eq3_biquad_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_l = '0, smp_r = '0;
  logic signed [15:0] cf [3][5];
  logic signed [15:0] cf_nx [3][5];
  logic signed [15:0] out_l, out_r;
  logic out_valid;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int mx1 [3][2], mx2 [3][2], my1 [3][2], my2 [3][2];
  int m_in [2];
  int m_y [3][2];

  always #4 clk = ~clk;

  eq3_biquad_core dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
    .lo_b0(cf[0][0]), .lo_b1(cf[0][1]), .lo_b2(cf[0][2]), .lo_a1(cf[0][3]), .lo_a2(cf[0][4]),
    .mid_b0(cf[1][0]), .mid_b1(cf[1][1]), .mid_b2(cf[1][2]), .mid_a1(cf[1][3]), .mid_a2(cf[1][4]),
    .hi_b0(cf[2][0]), .hi_b1(cf[2][1]), .hi_b2(cf[2][2]), .hi_a1(cf[2][3]), .hi_a2(cf[2][4]),
    .out_l(out_l), .out_r(out_r), .out_valid(out_valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 2; c++) begin
        mx1[s][c] = 0; mx2[s][c] = 0; my1[s][c] = 0; my2[s][c] = 0; m_y[s][c] = 0;
      end
    m_in[0] = 0; m_in[1] = 0;
  endtask

  // R3, R4, R5: one section step from the requirement equations
  function automatic int step(input int s, input int c, input int x);
    longint a;
    int r;
    a = longint'(cf[s][0]) * x + longint'(cf[s][1]) * mx1[s][c] + longint'(cf[s][2]) * mx2[s][c]
      - longint'(cf[s][3]) * my1[s][c] - longint'(cf[s][4]) * my2[s][c];
    a = (a + 64'sd8192) >>> 14;
    if (a > 32767) a = 32767;
    if (a < -32768) a = -32768;
    r = int'(a);
    mx2[s][c] = mx1[s][c]; mx1[s][c] = x;
    my2[s][c] = my1[s][c]; my1[s][c] = r;
    return r;
  endfunction

  task automatic set_neutral();
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 5; k++) cf[s][k] = (k == 0) ? 16'sh4000 : 16'sh0;
  endtask

  task automatic send(input int l, input int r, input string tag, input bit chg);
    int k, t0, t1, t2, el, er;
    for (int c = 0; c < 2; c++) begin
      t2 = step(2, c, m_y[1][c]);
      t1 = step(1, c, m_y[0][c]);
      t0 = step(0, c, m_in[c]);
      m_y[2][c] = t2; m_y[1][c] = t1; m_y[0][c] = t0;
    end
    m_in[0] = l; m_in[1] = r;
    el = m_y[2][0]; er = m_y[2][1];
    @(negedge clk);
    smp_l = 16'(l); smp_r = 16'(r); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    k = 1;
    while (!out_valid && k < 40) begin
      @(negedge clk);
      k++;
      if (chg && k == 3) cf = cf_nx;
    end
    check("R6 latency", k, 12);
    check({tag, " left"}, int'(out_l), el);
    check({tag, " right"}, int'(out_r), er);
    @(negedge clk);
  endtask

  function automatic int rnd(input int span);
    return int'($urandom_range(2 * span - 1)) - span;
  endfunction

  task automatic rand_coefs(output logic signed [15:0] dst [3][5]);
    for (int s = 0; s < 3; s++) begin
      dst[s][0] = 16'(rnd(16'h3000) + 16'h1000);
      dst[s][1] = 16'(rnd(16'h2000));
      dst[s][2] = 16'(rnd(16'h1000));
      dst[s][3] = 16'(rnd(16'h1000));
      dst[s][4] = 16'(rnd(16'h0800));
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20511));
    set_neutral();
    model_clear();
    repeat (4) @(negedge clk);
    check("R1 out_l in reset", int'(out_l), 0);
    check("R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_r after reset", int'(out_r), 0);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R2: neutral coefficients, output is input three strobes later
    send(1234, -4321, "R2", 0);
    send(32767, -32768, "R2", 0);
    send(-32768, 32767, "R2", 0);
    send(7, -7, "R2", 0);
    check("R2 delayed left", int'(out_l), 1234);
    send(0, 0, "R2", 0);
    check("R2 delayed left", int'(out_l), 32767);
    check("R2 delayed right", int'(out_r), -32768);
    send(0, 0, "R2", 0);
    send(0, 0, "R2", 0);

    // R4: gain one half in the low section; 0.5 -> 1, -0.5 -> 0, -1.5 -> -1
    cf[0][0] = 16'sh2000;
    send(1, -1, "R4", 0);
    send(3, -3, "R4", 0);
    send(5, -5, "R4", 0);
    repeat (3) send(0, 0, "R4", 0);

    // R5: near double gain at full scale clips
    cf[0][0] = 16'sh7FFF;
    send(32767, -32768, "R5", 0);
    send(20000, -20000, "R5", 0);
    send(-1, 1, "R5", 0);
    repeat (3) send(0, 0, "R5", 0);

    // R8: recursive low section, left impulse only
    set_neutral();
    cf[0][3] = -16'sh2000;
    send(10000, 0, "R8", 0);
    for (int i = 0; i < 6; i++) begin
      send(0, 0, "R8", 0);
      check("R8 right stays zero", int'(out_r), 0);
    end

    // R7: coefficients rewritten mid computation
    rand_coefs(cf);
    send(1000, -2000, "R7", 0);
    rand_coefs(cf_nx);
    send(3000, 1500, "R7", 1);
    send(-2500, 800, "R7", 0);
    send(400, -900, "R7", 0);
    send(0, 0, "R7", 0);

    // R3: random stimulus, coefficients refreshed in bursts
    for (int b = 0; b < 6; b++) begin
      rand_coefs(cf);
      for (int i = 0; i < 25; i++) send(rnd(32768), rnd(32768), "R3", 0);
    end

    // R9: reset during a ringing response
    set_neutral();
    cf[0][3] = -16'sh6000;
    cf[0][4] = 16'sh2400;
    send(8000, -8000, "R9", 0);
    send(0, 0, "R9", 0);
    send(0, 0, "R9", 0);
    do_reset();
    for (int i = 0; i < 5; i++) begin
      send(0, 0, "R9", 0);
      check("R9 left cleared", int'(out_l), 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule